// File: doc/BRIEF.md
# Card Bus Clock Divider with Start/Stop Gating

This block derives the card bus clock for an SD host from the faster system clock. The division has two stages. A prescaler either passes the system clock through or divides it by twice its programmed value. A small linear counter then divides the result by one more than its programmed value. Software writes both values through one rate word. It controls the clock through a control word that carries three strobes: start, stop and soft reset.

The output clock is a register on the system clock, so it never glitches. A new rate is taken up only at a period boundary, which is the last cycle of a low phase. A stop request waits for that same boundary, so every high pulse that has begun runs its full length. Alongside the clock the block drives a one-cycle enable on the system clock in the first cycle of every card-clock high phase. The command and data engines use this enable to advance their serial logic. A running flag reports whether the card clock is toggling.

There is no data path, so the block has no valid/ready interface. Both write ports are plain one-cycle strobes with no back-pressure. Each strobe is acted on at the rising system-clock edge where it is high.

Top module: `sdclk_gen`

## Requirements
- R1: The rate word carries the linear divider d in bits 3:0 and the prescaler p in bits 15:4. A write with `rate_we` high replaces both fields.
- R2: A linear divider d from 1 to 15 divides the prescaled clock by d+1, and d = 0 behaves as d = 1. Each period starts with floor((d+1)/2) high prescaled units, and the remaining units are low.
- R3: p = 0 bypasses the prescaler. A nonzero p divides the system clock by a further 2*p. The card period in system cycles is therefore (d+1) * (p == 0 ? 1 : 2*p).
- R4: A control write with bit 1 set (start) and bit 0 clear, made while the clock is stopped, starts the clock. `card_clk` goes high at the same edge and begins a full period.
- R5: A control write with bit 0 set (stop) made while the clock is running takes effect at the end of the current period's low phase. The last high pulse keeps its full length, and `card_clk` then stays low.
- R6: When start and stop are set in the same write, stop takes priority. A stopped clock stays stopped.
- R7: A control write with bit 3 set (soft reset) stops the clock at once and returns the rate word to 0. It overrides a start set in the same write. A later start write runs the clock at period 2.
- R8: `clk_running` is 1 exactly while the card clock is enabled. Whenever it is 0, `card_clk` is 0.
- R9: A rate write made while the clock is running leaves the period in progress at its old length. The new length applies from the next period.
- R10: `card_clk_en` is high for exactly one system cycle: the first cycle of each `card_clk` high phase.
- R11: After reset, `card_clk`, `card_clk_en` and `clk_running` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_we | input | 1 | Write strobe for the rate word |
| rate_wdata | input | 16 | Rate word: d in bits 3:0, p in bits 15:4 |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 4 | Control: bit 0 stop, bit 1 start, bit 3 soft reset, bit 2 unused |
| card_clk | output | 1 | Divided, gated card bus clock |
| card_clk_en | output | 1 | One-cycle pulse at each card clock rising edge |
| clk_running | output | 1 | Card clock enabled |

## Verification
The bench sweeps p over 0, 1, 2, 4 and 8 and d over 0 through 15. For each setting it measures the rise-to-rise period and the high width, and compares them with the formula. A design that mixed up the d = 0 case, the bypass case or the odd-ratio duty split would show a wrong count for that setting. After each sweep point the bench issues a stop and checks that the final high pulse had its full width and that the clock then stays low. A design that stopped as soon as the stop arrived would cut that last pulse short. Further tests write a new rate in the middle of a period, issue start and stop in the same write, and run the soft-reset sequence. These catch a rate taken up too early, a start that wrongly beats stop, and a reset that fails to clear the rate.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int CTRL_W        = 4;
  localparam int CTRL_STOP_IX  = 0;
  localparam int CTRL_START_IX = 1;
  localparam int CTRL_SRST_IX  = 3;

  typedef struct packed {
    logic srst;
    logic start;
    logic stop;
  } ctrl_req_t;

  function automatic ctrl_req_t decode_ctrl(input logic we, input logic [CTRL_W-1:0] w);
    ctrl_req_t r;
    r.srst  = we & w[CTRL_SRST_IX];
    r.start = we & w[CTRL_START_IX];
    r.stop  = we & w[CTRL_STOP_IX];
    return r;
  endfunction
endpackage

// File: rtl/sdclk_prescale.sv
module sdclk_prescale #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  localparam int CNT_W = PRE_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  // p == 0 ticks every cycle; otherwise every 2*p cycles
  assign last = (pre == '0) ? '0 : ({1'b0, pre} << 1) - CNT_W'(1);
  assign tick = (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/sdclk_lindiv.sv
module sdclk_lindiv #(
  parameter int LIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [LIN_W-1:0] div,
  output logic             wrap,
  output logic             hi_nxt
);
  logic [LIN_W-1:0] cnt_q, cnt_d, d_eff;
  logic [LIN_W:0]   hi_units;

  assign d_eff    = (div == '0) ? LIN_W'(1) : div;
  assign hi_units = ({1'b0, d_eff} + (LIN_W+1)'(1)) >> 1;
  assign wrap     = tick && (cnt_q == d_eff);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = wrap ? '0 : cnt_q + LIN_W'(1);
  end

  assign hi_nxt = ({1'b0, cnt_d} < hi_units);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sdclk_gate.sv
module sdclk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  input  logic srst,
  input  logic wrap,
  input  logic hi_nxt,
  output logic run,
  output logic clk_out,
  output logic clk_en
);
  logic run_q, run_d, pend_q, pend_d, clk_q, clk_d, en_q, stop_req;

  always_comb begin
    run_d    = run_q;
    pend_d   = pend_q;
    clk_d    = clk_q;
    stop_req = pend_q || stop;
    if (srst) begin
      run_d  = 1'b0;
      pend_d = 1'b0;
      clk_d  = 1'b0;
    end else if (!run_q) begin
      pend_d = 1'b0;
      if (start && !stop) begin
        run_d = 1'b1;
        clk_d = 1'b1;
      end
    end else if (wrap && stop_req) begin
      run_d  = 1'b0;
      pend_d = 1'b0;
      clk_d  = 1'b0;
    end else begin
      pend_d = stop || (pend_q && !start);
      clk_d  = hi_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      clk_q  <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      run_q  <= run_d;
      pend_q <= pend_d;
      clk_q  <= clk_d;
      en_q   <= clk_d & ~clk_q;
    end
  end

  assign run     = run_q;
  assign clk_out = clk_q;
  assign clk_en  = en_q;

  // R5: an orderly stop only lands after a low cycle
  a_r5_stop_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(run_q) && !$past(srst)) |-> (!clk_q && !$past(clk_q)));
  // R6: start together with stop never starts a stopped clock
  a_r6_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && start && stop) |=> !run_q);
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
  parameter int LIN_W = 4,
  parameter int PRE_W = 12,
  localparam int RATE_W = LIN_W + PRE_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rate_we,
  input  logic [RATE_W-1:0]           rate_wdata,
  input  logic                        ctrl_we,
  input  logic [sdclk_pkg::CTRL_W-1:0] ctrl_wdata,
  output logic                        card_clk,
  output logic                        card_clk_en,
  output logic                        clk_running
);
  import sdclk_pkg::*;

  ctrl_req_t         req;
  logic [RATE_W-1:0] rate_q, rate_d, act_q;
  logic              run, wrap, tick, hi_nxt;

  assign req = decode_ctrl(ctrl_we, ctrl_wdata);

  always_comb begin
    rate_d = rate_q;
    if (req.srst)     rate_d = '0;
    else if (rate_we) rate_d = rate_wdata;
  end

  // shadow word and active word; active follows only at a period boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      act_q  <= '0;
    end else begin
      rate_q <= rate_d;
      if (!run || wrap) act_q <= rate_d;
    end
  end

  sdclk_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(!run),
    .pre(act_q[RATE_W-1:LIN_W]), .tick(tick)
  );

  sdclk_lindiv #(.LIN_W(LIN_W)) u_lin (
    .clk(clk), .rst_n(rst_n), .clr(!run), .tick(tick),
    .div(act_q[LIN_W-1:0]), .wrap(wrap), .hi_nxt(hi_nxt)
  );

  sdclk_gate u_gate (
    .clk(clk), .rst_n(rst_n), .start(req.start), .stop(req.stop),
    .srst(req.srst), .wrap(wrap), .hi_nxt(hi_nxt),
    .run(run), .clk_out(card_clk), .clk_en(card_clk_en)
  );

  assign clk_running = run;

  // R10: enable marks the first high cycle only
  a_r10_en_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    card_clk_en |-> (card_clk && !$past(card_clk)));
  // R8: a stopped clock is low
  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_running |-> !card_clk);
  // R7: soft reset halts at once
  a_r7_srst_halts: assert property (@(posedge clk) disable iff (!rst_n)
    req.srst |=> (!clk_running && !card_clk));
  // R9: the active rate stays put inside a running period
  a_r9_rate_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && run && !$past(wrap)) |-> $stable(act_q));
endmodule

// File: tb/sdclk_gen_tb.sv
module sdclk_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rate_we = 1'b0;
  logic [15:0] rate_wdata = '0;
  logic        ctrl_we = 1'b0;
  logic [3:0]  ctrl_wdata = '0;
  logic        card_clk, card_clk_en, clk_running;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, rise_cyc = 0, rises = 0, hcnt = 0;
  int last_period = 0, last_high = 0, en_err = 0;
  logic prev = 1'b0;

  always #4 clk = ~clk;

  sdclk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .rate_we(rate_we), .rate_wdata(rate_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .card_clk(card_clk),
    .card_clk_en(card_clk_en), .clk_running(clk_running)
  );

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (card_clk_en !== (card_clk && !prev)) en_err = en_err + 1;
      if (card_clk && !prev) begin
        last_period = cyc - rise_cyc;
        rise_cyc = cyc;
        rises = rises + 1;
        hcnt = 1;
      end else if (card_clk) hcnt = hcnt + 1;
      if (!card_clk && prev) last_high = hcnt;
    end
    prev = card_clk;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk = n_chk + 1;
    n_fail = n_fail + 1;
    $display("FAIL watchdog: run did not complete, act=timeout exp=done");
    summary();
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_rate(input int p, input int d);
    @(negedge clk);
    rate_we = 1'b1;
    rate_wdata = {p[11:0], d[3:0]};
    @(negedge clk);
    rate_we = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [3:0] v);
    @(negedge clk);
    ctrl_we = 1'b1;
    ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wait_rises(input int n);
    int tgt = rises + n;
    for (int i = 0; i < 4000 && rises < tgt; i++) @(negedge clk);
  endtask

  task automatic wait_stop();
    for (int i = 0; i < 4000 && clk_running; i++) @(negedge clk);
  endtask

  function automatic int exp_per(input int p, input int d);
    int de = (d == 0) ? 1 : d;
    return (de + 1) * ((p == 0) ? 1 : 2 * p);
  endfunction

  function automatic int exp_hi(input int p, input int d);
    int de = (d == 0) ? 1 : d;
    return ((de + 1) / 2) * ((p == 0) ? 1 : 2 * p);
  endfunction

  initial begin
    int r0;
    int plist[5] = '{0, 1, 2, 4, 8};
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!card_clk && !card_clk_en && !clk_running, "R11 reset outputs", card_clk, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R5: sweep of prescaler and divider
    foreach (plist[k]) begin
      for (int d = 0; d < 16; d++) begin
        int p = plist[k];
        wr_rate(p, d);
        wr_ctrl(4'b0010);
        chk(clk_running == 1'b1, "R4 start raises running", clk_running, 1);
        wait_rises(3);
        chk(last_period == exp_per(p, d), "R3 period", last_period, exp_per(p, d));
        chk(last_high == exp_hi(p, d), "R2 high width", last_high, exp_hi(p, d));
        wr_ctrl(4'b0001);
        wait_stop();
        chk(!card_clk && !clk_running, "R5 stopped low", card_clk, 0);
        chk(last_high == exp_hi(p, d), "R5 last pulse full", last_high, exp_hi(p, d));
        r0 = rises;
        repeat (40) @(negedge clk);
        chk(rises == r0 && !card_clk, "R5 stays low", rises - r0, 0);
      end
    end
    chk(en_err == 0, "R10 enable matches rising edges", en_err, 0);

    // R6: start with stop while stopped
    r0 = rises;
    wr_ctrl(4'b0011);
    repeat (30) @(negedge clk);
    chk(!clk_running && rises == r0, "R6 stop beats start", clk_running, 0);

    // R9: rate change mid-period
    wr_rate(1, 3);
    wr_ctrl(4'b0010);
    wait_rises(2);
    @(negedge clk);
    rate_we = 1'b1;
    rate_wdata = {12'd0, 4'd5};
    @(negedge clk);
    rate_we = 1'b0;
    wait_rises(1);
    chk(last_period == 8, "R9 current period keeps old rate", last_period, 8);
    wait_rises(1);
    chk(last_period == 6, "R9 next period uses new rate", last_period, 6);
    chk(last_high == 3, "R9 new high width", last_high, 3);

    // R6: start with stop while running still stops
    wr_ctrl(4'b0011);
    wait_stop();
    chk(!clk_running && !card_clk, "R6 combined write stops running clock", clk_running, 0);

    // R7 R8: soft reset sequence
    wr_rate(2, 3);
    wr_ctrl(4'b0010);
    wait_rises(2);
    repeat (3) @(negedge clk);
    wr_ctrl(4'b1000);
    chk(!clk_running && !card_clk, "R7 soft reset halts", clk_running, 0);
    wr_ctrl(4'b1010);
    chk(!clk_running, "R7 reset overrides start", clk_running, 0);
    for (int i = 0; i < 8; i++) wr_ctrl(4'b0010);
    chk(clk_running == 1'b1, "R8 running after start", clk_running, 1);
    wait_rises(3);
    chk(last_period == 2, "R7 rate cleared to zero", last_period, 2);
    chk(en_err == 0, "R10 enable after reset sequence", en_err, 0);
    summary();
  end
endmodule